// File: doc/BRIEF.md
# Sequenced Sine and Square Tone Generator

This block produces an unsigned 8-bit sample stream for a resistor-ladder audio DAC by direct digital synthesis. A table holding one full sine period in 256 entries is read through an 8-bit phase index. A cycle divider moves the index forward by one each time it has counted a threshold number of clocks. The pitch is therefore the clock rate divided by 256 and by the threshold. The table is built from a constant function when the design is elaborated, so no memory image is needed.

A two-bit mode input picks one of three behaviours. In fixed mode the threshold comes from an input port. In tune mode a built-in schedule loops over three tones, and each tone lasts a fixed number of index advances. In square mode the index flips between two table entries that hold the waveform's extremes, at a slow fixed rate. Any change of the mode code restarts the divider, the schedule and the index, so every new mode begins from a known phase.

Top module: `dds_tone_gen`

## Requirements
- R1: While reset is held and on leaving it, `phase_idx` is 0, or 64 when `mode` is 2. `sample` is 127 and `tone_sel` is 0.
- R2: `sample` equals the table entry addressed by the value `phase_idx` held in the previous clock cycle.
- R3: Table entry i is floor(127.5 + 127.5·sin(2πi/256)), clamped to 0..255. This gives entry 0 = 127, 64 = 255, 128 = 127 and 188 = 0.
- R4: With `mode` 0 or 3 (fixed mode) and a threshold T ≥ 2 on `fixed_thr`, `phase_idx` rises by exactly one every T clocks and wraps from 255 to 0.
- R5: In fixed mode a `fixed_thr` of 0 or 1 makes `phase_idx` advance on every clock.
- R6: If `fixed_thr` is lowered below the clocks already counted since the last advance, the index advances on the next clock. The new period applies from then on.
- R7: With `mode` 1 (tune mode), advances 0..LEN_A−1 are spaced THR_A clocks apart with `tone_sel` = 0. The next LEN_B advances are spaced THR_B apart with `tone_sel` = 1. The next LEN_C advances are spaced THR_C apart with `tone_sel` = 2. The spacing named is the interval that ends in that advance.
- R8: After LEN_A+LEN_B+LEN_C advances, tune mode returns to the first tone and repeats the schedule without a gap.
- R9: With `mode` 2 (square mode), `phase_idx` alternates between 64 and 188 and starts at 64. Each value is held for SQ_HALF clocks.
- R10: On the first clock edge that sees a new `mode` code, the divider and the schedule are cleared and `phase_idx` goes to 0 (64 for square mode). The first advance follows one full period of the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0/3 fixed tone, 1 three-tone loop, 2 square wave |
| fixed_thr | input | DIV_W | Clocks per index advance in fixed mode |
| sample | output | SAMP_W | Registered unsigned DAC code |
| phase_idx | output | IDX_W | Current table index |
| tone_sel | output | 2 | Tone currently playing in tune mode (0, 1, 2) |

## Verification
The corner cases targeted are these:
- An off-by-one divider would space advances T+1 clocks apart instead of T.
- A threshold of 0 or 1 could stall the divider or underflow it into a 2^DIV_W-long period.
- Lowering the threshold mid-count could leave an equality comparator waiting for a full counter wrap.
- In the tune schedule, each segment boundary and the loop point are measured interval by interval. A segment decoded one advance late, or a wrap that misses the last advance, shows up as a wrong spacing at exactly that advance.
- Mode switches are checked for a restarted phase, so a design that kept the old divider count would produce a short first period.
- Table entries at the midscale, peak and trough positions are compared with the expected codes, and the sample is checked to lag the index by one cycle.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED     = 2'd0,
        MODE_TUNE      = 2'd1,
        MODE_SQUARE    = 2'd2,
        MODE_FIXED_ALT = 2'd3
    } tone_mode_e;

    localparam real TWO_PI = 6.283185307179586;

    // Odd Taylor series, accurate to ~1e-9 on [0, pi/2]
    function automatic real quarter_sin(input real x);
        real x2;
        real term;
        real acc;
        x2   = x * x;
        term = x;
        acc  = x;
        for (int k = 1; k <= 8; k++) begin
            term = -term * x2 / (real'(2 * k) * real'(2 * k + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Unsigned code for table entry i of a depth-entry sine period
    function automatic int sine_code(input int i, input int depth, input int width);
        int  quarter;
        int  quad;
        int  rem;
        real step;
        real s;
        real full;
        real v;
        quarter = depth / 4;
        quad    = i / quarter;
        rem     = i % quarter;
        step    = TWO_PI / real'(depth);
        case (quad)
            0:       s =  quarter_sin(real'(rem) * step);
            1:       s =  quarter_sin(real'(quarter - rem) * step);
            2:       s = -quarter_sin(real'(rem) * step);
            default: s = -quarter_sin(real'(quarter - rem) * step);
        endcase
        full = real'((1 << width) - 1);
        v    = full / 2.0 + (full / 2.0) * s + 1.0e-6;
        if (v < 0.0)  v = 0.0;
        if (v > full) v = full;
        return $rtoi(v);
    endfunction

endpackage

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
    parameter int IDX_W  = 8,
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    output logic [SAMP_W-1:0] sample
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [SAMP_W-1:0] MID_CODE = SAMP_W'((1 << (SAMP_W - 1)) - 1);

    typedef struct packed {
        logic [SAMP_W-1:0] code;
    } rom_st_t;

    logic [SAMP_W-1:0] lut [DEPTH];
    rom_st_t rom_d, rom_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_lut
        localparam int CODE = tone_pkg::sine_code(g, DEPTH, SAMP_W);
        assign lut[g] = SAMP_W'(CODE);
    end

    always_comb begin
        rom_d      = rom_q;
        rom_d.code = lut[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) rom_q <= '{code: MID_CODE};
        else     rom_q <= rom_d;
    end

    assign sample = rom_q.code;

    AST_RESET_MID: assert property (@(posedge clk)
        $past(rst) |-> (sample == MID_CODE || !rst)) else $error("reset code");  // R1

endmodule

// File: rtl/tone_sequencer.sv
module tone_sequencer #(
    parameter int DIV_W = 20,
    parameter int SEQ_W = 21,
    parameter int THR_A = 96,
    parameter int THR_B = 48,
    parameter int THR_C = 144,
    parameter int LEN_A = 300000,
    parameter int LEN_B = 600000,
    parameter int LEN_C = 200000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    output logic [DIV_W-1:0] thr,
    output logic [1:0]       seg
);
    localparam int END_A = LEN_A;
    localparam int END_B = LEN_A + LEN_B;
    localparam int TOTAL = END_B + LEN_C;
    localparam logic [SEQ_W-1:0] END_A_V = SEQ_W'(END_A);
    localparam logic [SEQ_W-1:0] END_B_V = SEQ_W'(END_B);
    localparam logic [SEQ_W-1:0] LAST_V  = SEQ_W'(TOTAL - 1);
    localparam logic [DIV_W-1:0] THR_A_V = DIV_W'(THR_A);
    localparam logic [DIV_W-1:0] THR_B_V = DIV_W'(THR_B);
    localparam logic [DIV_W-1:0] THR_C_V = DIV_W'(THR_C);

    typedef struct packed {
        logic [SEQ_W-1:0] cnt;
    } seq_st_t;

    seq_st_t seq_d, seq_q;

    // Threshold and tone id decoded from the advance count
    always_comb begin
        if (seq_q.cnt < END_A_V) begin
            thr = THR_A_V;
            seg = 2'd0;
        end else if (seq_q.cnt < END_B_V) begin
            thr = THR_B_V;
            seg = 2'd1;
        end else begin
            thr = THR_C_V;
            seg = 2'd2;
        end
    end

    always_comb begin
        seq_d = seq_q;
        if (restart) begin
            seq_d.cnt = '0;
        end else if (step) begin
            if (seq_q.cnt == LAST_V) seq_d.cnt = '0;
            else                     seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '{cnt: '0};
        else     seq_q <= seq_d;
    end

    AST_SEG_RANGE: assert property (@(posedge clk) disable iff (rst)
        seq_q.cnt <= LAST_V) else $error("count beyond schedule");  // R8
    AST_SEG_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !restart && seq_q.cnt == LAST_V) |=> (seq_q.cnt == '0 && seg == 2'd0)) else $error("no wrap");  // R8
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !restart) |=> $stable(seq_q.cnt)) else $error("count moved without advance");  // R7

endmodule

// File: rtl/dds_tone_gen.sv
module dds_tone_gen #(
    parameter int DIV_W   = 20,
    parameter int IDX_W   = 8,
    parameter int SAMP_W  = 8,
    parameter int SEQ_W   = 21,
    parameter int THR_A   = 96,
    parameter int THR_B   = 48,
    parameter int THR_C   = 144,
    parameter int LEN_A   = 300000,
    parameter int LEN_B   = 600000,
    parameter int LEN_C   = 200000,
    parameter int SQ_HALF = 250000,
    parameter int SQ_LO   = 64,
    parameter int SQ_HI   = 188
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [DIV_W-1:0]  fixed_thr,
    output logic [SAMP_W-1:0] sample,
    output logic [IDX_W-1:0]  phase_idx,
    output logic [1:0]        tone_sel
);
    import tone_pkg::*;

    localparam logic [DIV_W-1:0] THR_ONE   = DIV_W'(1);
    localparam logic [DIV_W-1:0] SQ_HALF_V = DIV_W'(SQ_HALF);
    localparam logic [IDX_W-1:0] SQ_LO_V   = IDX_W'(SQ_LO);
    localparam logic [IDX_W-1:0] SQ_HI_V   = IDX_W'(SQ_HI);

    typedef struct packed {
        logic [1:0]       mode;
        logic [DIV_W-1:0] div;
        logic [IDX_W-1:0] idx;
    } core_st_t;

    core_st_t         core_d, core_q;
    logic             mode_chg;
    logic             adv;
    logic [DIV_W-1:0] eff_thr;
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] seq_thr;
    logic [IDX_W-1:0] start_idx;

    assign mode_chg  = (mode != core_q.mode);
    assign start_idx = (mode == MODE_SQUARE) ? SQ_LO_V : '0;

    always_comb begin
        case (core_q.mode)
            MODE_TUNE:   eff_thr = seq_thr;
            MODE_SQUARE: eff_thr = SQ_HALF_V;
            default:     eff_thr = fixed_thr;
        endcase
        limit = (eff_thr <= THR_ONE) ? '0 : eff_thr - THR_ONE;
    end

    always_comb begin
        core_d = core_q;
        adv    = 1'b0;
        if (mode_chg) begin
            core_d.mode = mode;
            core_d.div  = '0;
            core_d.idx  = start_idx;
        end else if (core_q.div >= limit) begin
            adv        = 1'b1;
            core_d.div = '0;
            if (core_q.mode == MODE_SQUARE)
                core_d.idx = (core_q.idx == SQ_LO_V) ? SQ_HI_V : SQ_LO_V;
            else
                core_d.idx = core_q.idx + 1'b1;
        end else begin
            core_d.div = core_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '{mode: mode, div: '0, idx: start_idx};
        else     core_q <= core_d;
    end

    tone_sequencer #(
        .DIV_W(DIV_W), .SEQ_W(SEQ_W),
        .THR_A(THR_A), .THR_B(THR_B), .THR_C(THR_C),
        .LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_C(LEN_C)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .restart (mode_chg),
        .step    (adv && (core_q.mode == MODE_TUNE)),
        .thr     (seq_thr),
        .seg     (tone_sel)
    );

    tone_sine_rom #(
        .IDX_W  (IDX_W),
        .SAMP_W (SAMP_W)
    ) u_rom (
        .clk    (clk),
        .rst    (rst),
        .idx    (core_q.idx),
        .sample (sample)
    );

    assign phase_idx = core_q.idx;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (core_q.mode != MODE_SQUARE && core_q.mode == $past(core_q.mode) && core_q.idx != $past(core_q.idx))
        |-> core_q.idx == IDX_W'($past(core_q.idx) + 1'b1)) else $error("index skipped");  // R4
    AST_SQ_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (core_q.mode == MODE_SQUARE) |-> (core_q.idx == SQ_LO_V || core_q.idx == SQ_HI_V)) else $error("square level");  // R9
    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (core_q.div == '0 && tone_sel == 2'd0)) else $error("restart not clean");  // R10

endmodule

// File: tb/dds_tone_gen_tb.sv
module dds_tone_gen_tb;
    localparam int DW  = 8;
    localparam int TA  = 4;
    localparam int TB  = 2;
    localparam int TC  = 6;
    localparam int LA  = 5;
    localparam int LB  = 8;
    localparam int LC  = 3;
    localparam int SQH = 10;
    localparam int TOT = LA + LB + LC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic [DW-1:0] thr = DW'(7);
    logic [7:0]    sample;
    logic [7:0]    phase_idx;
    logic [1:0]    tone_sel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    dds_tone_gen #(
        .DIV_W(DW), .IDX_W(8), .SAMP_W(8), .SEQ_W(6),
        .THR_A(TA), .THR_B(TB), .THR_C(TC),
        .LEN_A(LA), .LEN_B(LB), .LEN_C(LC),
        .SQ_HALF(SQH), .SQ_LO(64), .SQ_HI(188)
    ) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .fixed_thr(thr),
        .sample(sample), .phase_idx(phase_idx), .tone_sel(tone_sel)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_sine(input int i);
        real v;
        v = $floor(127.5 + 127.5 * $sin(6.283185307179586 * real'(i) / 256.0) + 1.0e-6);
        if (v < 0.0)   v = 0.0;
        if (v > 255.0) v = 255.0;
        return $rtoi(v);
    endfunction

    task automatic do_reset(input logic [1:0] m, input int t);
        @(negedge clk);
        rst  = 1'b1;
        mode = m;
        thr  = DW'(t);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // clock edges until phase_idx changes, sampled at negedges
    task automatic wait_change(output int n);
        logic [7:0] start;
        start = phase_idx;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (phase_idx == start && n < 1000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; mode = 2'd0; thr = DW'(7);
        repeat (2) @(negedge clk);
        chk(phase_idx == 8'd0, "R1 idx", phase_idx, 0);
        chk(sample == 8'd127, "R1 sample", sample, 127);
        chk(tone_sel == 2'd0, "R1 tone_sel", tone_sel, 0);
        mode = 2'd2;
        repeat (2) @(negedge clk);
        chk(phase_idx == 8'd64, "R1 square idx", phase_idx, 64);
        rst = 1'b0;
    endtask

    task automatic t_table();
        logic [7:0] prev;
        do_reset(2'd0, 1);
        for (int k = 0; k < 260; k++) begin
            prev = phase_idx;
            @(negedge clk);
            chk(phase_idx == 8'(prev + 1), (prev == 8'd255) ? "R4 wrap" : "R5 thr1", phase_idx, (prev + 1) % 256);
            chk(int'(sample) == ref_sine(prev), "R2 latency", sample, ref_sine(prev));
            if (prev == 8'd0)   chk(sample == 8'd127, "R3 entry0", sample, 127);
            if (prev == 8'd64)  chk(sample == 8'd255, "R3 entry64", sample, 255);
            if (prev == 8'd128) chk(sample == 8'd127, "R3 entry128", sample, 127);
            if (prev == 8'd188) chk(sample == 8'd0, "R3 entry188", sample, 0);
        end
        thr = DW'(0);
        for (int k = 0; k < 4; k++) begin
            prev = phase_idx;
            @(negedge clk);
            chk(phase_idx == 8'(prev + 1), "R5 thr0", phase_idx, (prev + 1) % 256);
        end
    endtask

    task automatic t_fixed();
        int n;
        do_reset(2'd0, 7);
        for (int k = 0; k < 3; k++) begin
            wait_change(n);
            chk(n == 7, "R4 period", n, 7);
        end
        mode = 2'd3; thr = DW'(5);
        @(negedge clk);
        chk(phase_idx == 8'd0, "R10 idx on 0->3", phase_idx, 0);
        wait_change(n);
        chk(n == 5, "R4 code3 period", n, 5);
        wait_change(n);
        chk(n == 5, "R4 code3 period", n, 5);
    endtask

    task automatic t_lower();
        int n;
        do_reset(2'd0, 20);
        wait_change(n);
        chk(n == 20, "R4 period20", n, 20);
        repeat (10) @(negedge clk);
        thr = DW'(3);
        wait_change(n);
        chk(n == 1, "R6 immediate", n, 1);
        wait_change(n);
        chk(n == 3, "R6 new period", n, 3);
    endtask

    task automatic t_tune();
        int n;
        int p;
        int et;
        int es;
        do_reset(2'd1, 0);
        for (int k = 0; k < 2 * TOT; k++) begin
            p  = k % TOT;
            et = (p < LA) ? TA : (p < LA + LB) ? TB : TC;
            es = (p < LA) ? 0 : (p < LA + LB) ? 1 : 2;
            chk(int'(tone_sel) == es, (k >= TOT) ? "R8 tone_sel" : "R7 tone_sel", tone_sel, es);
            wait_change(n);
            chk(n == et, (k >= TOT) ? "R8 spacing" : "R7 spacing", n, et);
        end
    endtask

    task automatic t_square();
        int n;
        do_reset(2'd2, 0);
        chk(phase_idx == 8'd64, "R1 square start", phase_idx, 64);
        for (int k = 0; k < 4; k++) begin
            wait_change(n);
            chk(n == SQH, "R9 half period", n, SQH);
            chk(phase_idx == ((k % 2 == 0) ? 8'd188 : 8'd64), "R9 level", phase_idx, (k % 2 == 0) ? 188 : 64);
        end
        mode = 2'd1;
        @(negedge clk);
        chk(phase_idx == 8'd0, "R10 square->tune idx", phase_idx, 0);
        mode = 2'd2;
        @(negedge clk);
        chk(phase_idx == 8'd64, "R10 tune->square idx", phase_idx, 64);
        wait_change(n);
        chk(n == SQH, "R10 square restart period", n, SQH);
    endtask

    task automatic t_mode_change();
        int n;
        do_reset(2'd1, 0);
        for (int k = 0; k < 7; k++) wait_change(n);
        chk(tone_sel == 2'd1, "R7 mid tone", tone_sel, 1);
        mode = 2'd0; thr = DW'(9);
        @(negedge clk);
        chk(phase_idx == 8'd0, "R10 idx", phase_idx, 0);
        chk(tone_sel == 2'd0, "R10 tone_sel", tone_sel, 0);
        wait_change(n);
        chk(n == 9, "R10 fixed period", n, 9);
        mode = 2'd1;
        @(negedge clk);
        chk(phase_idx == 8'd0, "R10 back to tune idx", phase_idx, 0);
        chk(tone_sel == 2'd0, "R10 schedule restarted", tone_sel, 0);
        wait_change(n);
        chk(n == TA, "R10 first tone", n, TA);
    endtask

    initial begin
        t_reset();
        t_table();
        t_fixed();
        t_lower();
        t_tune();
        t_square();
        t_mode_change();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule